// File: doc/BRIEF.md
# Reference-Aligned Seconds Prescaler

This block turns a 32.768 kHz low-speed clock into two tick streams: a fast tick from a first counter stage (256 Hz at the nominal reload of 127) and a one-second tick from a second stage that counts fast ticks (nominal reload 255). Both stages run on the low-speed clock, and the calendar they feed is always timed by that clock.

When reference detection is enabled, a slow but accurate signal such as a 50 or 60 Hz mains square wave is synchronized into the clock domain. Its rising edges are compared against a window placed around each expected second boundary. An edge inside the window restarts both counter stages from zero, so that the next second boundaries are aligned with the reference. The window is wide while the block is searching for the reference and narrow while it is tracking. If a tracking window passes without an edge, the block drops its lock and returns to the wide window. Software must program reload values 127 and 255 while detection is on. The block does not enforce this.

Top module: `rtc_ref_align`

## Requirements
- R1: `tick_apre` is high exactly when the first-stage count equals (or exceeds) `prediv_a`. The count runs from 0 to `prediv_a` and then wraps, so without reference action the tick repeats every `prediv_a`+1 clock cycles.
- R2: Without reference action, `tick_spre` is high only together with `tick_apre`, on every (`prediv_s`+1)-th fast tick. Its period is therefore (`prediv_a`+1)*(`prediv_s`+1) cycles.
- R3: While `det_en` is low, `ref_in` has no effect on either tick. `ref_locked` is low in the cycle after any cycle in which `det_en` is low.
- R4: A rising edge of `ref_in` that is present at clock edge k acts during the cycle after edge k+1, through a two-flop synchronizer and an edge detector. Measured from the falling edge where `ref_in` is raised, any forced tick appears two cycles later.
- R5: Let s be the second-stage count (0..`prediv_s`) and h the half-window (3 while unlocked, 1 while locked). The window is open when s >= `prediv_s`-h (the closing part of a second) or when s < h (the opening part of the next second).
- R6: A reference edge in the closing part of an open window emits `tick_spre` in that cycle, restarts both stages from zero and sets `ref_locked` in the next cycle.
- R7: A reference edge in the opening part of an open window restarts both stages without a tick and sets `ref_locked`.
- R8: A reference edge that coincides with a natural one-second tick leaves the tick spacing unchanged.
- R9: Within one open window at most one restart is taken. Later reference edges in the same window are ignored.
- R10: When a window closes while `ref_locked` is high and no restart was taken in it, `ref_locked` falls. Ticks then continue from the low-speed clock alone, and the wide window applies again.
- R11: During reset both counts are zero, both ticks are low (for nonzero reload values) and `ref_locked` is low. The first `tick_apre` comes `prediv_a` cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock (32.768 kHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_en | input | 1 | Enables reference detection and alignment |
| ref_in | input | 1 | Asynchronous reference signal |
| prediv_a | input | A_W | First-stage reload value |
| prediv_s | input | S_W | Second-stage reload value |
| tick_apre | output | 1 | First-stage tick, one cycle wide |
| tick_spre | output | 1 | One-second tick, one cycle wide |
| ref_locked | output | 1 | High while the reference is being tracked |

## Verification
The assertions check on every cycle that the lock is cleared after detection is disabled, and that it rises only after a synchronized reference pulse. They also check that it falls only at a window close or on disable, that an unforced one-second tick always coincides with a fast tick, that the synchronized pulse lasts one cycle, and that no window takes a second restart. The exact placement of the windows cannot be seen from single cycles. Only the bench scenarios can show it: acquisition, shifts in both directions, rejection by the narrow window followed by capture in the wide one, loss of the reference, and the exact cycle of each tick.

// File: rtl/rtc_ref_align.sv
module rtc_ref_align #(
  parameter int A_W        = 7,
  parameter int S_W        = 15,
  parameter int WIDE_WIN   = 7,
  parameter int NARROW_WIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           det_en,
  input  logic           ref_in,
  input  logic [A_W-1:0] prediv_a,
  input  logic [S_W-1:0] prediv_s,
  output logic           tick_apre,
  output logic           tick_spre,
  output logic           ref_locked
);

  localparam int CW          = S_W + 1;
  localparam int WIDE_HALF   = WIDE_WIN / 2;
  localparam int NARROW_HALF = NARROW_WIN / 2;

  logic [A_W-1:0] a_cnt;
  logic [S_W-1:0] s_cnt;
  logic [2:0]     ref_sync;
  logic           win_q, win_used;

  logic           ref_pulse, a_term, s_term;
  logic [CW-1:0]  half, s_ext, p_ext;
  logic           in_before, in_after, win_open, force_rl, win_close;

  assign ref_pulse = ref_sync[1] & ~ref_sync[2];
  assign a_term    = a_cnt >= prediv_a;
  assign s_term    = s_cnt >= prediv_s;

  assign half      = ref_locked ? CW'(NARROW_HALF) : CW'(WIDE_HALF);
  assign s_ext     = {1'b0, s_cnt};
  assign p_ext     = {1'b0, prediv_s};
  assign in_before = (s_ext + half) >= p_ext;
  assign in_after  = s_ext < half;
  assign win_open  = det_en & (in_before | in_after);
  assign force_rl  = ref_pulse & win_open & ~win_used;
  assign win_close = win_q & ~win_open;

  assign tick_apre = a_term;
  assign tick_spre = (a_term & s_term) | (force_rl & in_before);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_sync <= '0;
    else        ref_sync <= {ref_sync[1:0], ref_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt <= '0;
      s_cnt <= '0;
    end else if (force_rl) begin
      a_cnt <= '0;
      s_cnt <= '0;
    end else if (a_term) begin
      a_cnt <= '0;
      s_cnt <= s_term ? '0 : s_cnt + S_W'(1);
    end else begin
      a_cnt <= a_cnt + A_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q      <= 1'b0;
      win_used   <= 1'b0;
      ref_locked <= 1'b0;
    end else begin
      win_q <= win_open;
      if (!win_open)     win_used <= 1'b0;
      else if (force_rl) win_used <= 1'b1;
      if (!det_en)                           ref_locked <= 1'b0;
      else if (force_rl)                     ref_locked <= 1'b1;
      else if (win_close && !win_used)       ref_locked <= 1'b0;
    end
  end

endmodule

// File: rtl/rtc_ref_align_chk.sv
module rtc_ref_align_chk (
  input logic clk,
  input logic rst_n,
  input logic det_en,
  input logic tick_apre,
  input logic tick_spre,
  input logic ref_locked,
  input logic ref_pulse,
  input logic force_rl,
  input logic win_open,
  input logic win_q
);

  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen <= 1'b0;
    else if (!win_open) seen <= 1'b0;
    else if (force_rl)  seen <= 1'b1;
  end

  a_r3_lock_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !ref_locked);

  a_r2_spre_on_apre: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_spre && !force_rl) |-> tick_apre);

  a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  a_r6_lock_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_locked) |-> $past(ref_pulse));

  a_r9_one_reload: assert property (@(posedge clk) disable iff (!rst_n)
    force_rl |-> !seen);

  a_r10_drop_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_locked) |-> ($past(!det_en) || ($past(win_q) && !$past(win_open))));

endmodule

bind rtc_ref_align rtc_ref_align_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .det_en     (det_en),
  .tick_apre  (tick_apre),
  .tick_spre  (tick_spre),
  .ref_locked (ref_locked),
  .ref_pulse  (ref_pulse),
  .force_rl   (force_rl),
  .win_open   (win_open),
  .win_q      (win_q)
);

// File: tb/rtc_ref_align_tb_top.sv
module rtc_ref_align_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        det_en = 1'b0;
  logic        ref_in = 1'b0;
  logic [6:0]  prediv_a = 7'd3;
  logic [14:0] prediv_s = 15'd15;
  logic        tick_apre, tick_spre, ref_locked;

  always #2 clk = ~clk;

  rtc_ref_align dut_i (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .ref_in(ref_in),
    .prediv_a(prediv_a), .prediv_s(prediv_s),
    .tick_apre(tick_apre), .tick_spre(tick_spre), .ref_locked(ref_locked)
  );

  // {prediv_a, prediv_s, fast-tick period, second-tick period}
  localparam int VEC [5][4] = '{
    '{3, 15, 4, 64}, '{0, 3, 1, 4}, '{1, 7, 2, 16},
    '{5, 2, 6, 18}, '{127, 255, 128, 32768}
  };

  int checks = 0, errors = 0, ncyc = 0, nspre = 0, nrise = 0, wd = 0;
  int spre_log [16];
  int rises [8];
  logic lock_hist [512];
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    ncyc++;
    if (tick_spre && nspre < 16) begin spre_log[nspre] = ncyc; nspre++; end
    lock_hist[ncyc % 512] = ref_locked;
    ref_in = 1'b0;
    for (int i = 0; i < nrise; i++)
      if (ncyc >= rises[i] && ncyc <= rises[i] + 1) ref_in = 1'b1;
  endtask

  task automatic do_reset(input int pa, input int ps, input bit en);
    rst_n = 1'b0; nrise = 0; ref_in = 1'b0;
    prediv_a = 7'(pa); prediv_s = 15'(ps); det_en = en;
    repeat (3) cycle();
    rst_n = 1'b1;
    nspre = 0;
  endtask

  task automatic sync_t0(output int t0);
    for (int g = 0; g < 70000 && nspre == 0; g++) cycle();
    t0 = spre_log[0];
    nspre = 0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0, rel, t1;

    // R11: reset state and first fast tick after release
    do_reset(3, 15, 1'b0);
    chk("R11 apre in reset", int'(tick_apre), 0);
    chk("R11 spre in reset", int'(tick_spre), 0);
    chk("R11 lock in reset", int'(ref_locked), 0);
    rel = ncyc;
    for (int g = 0; g < 20 && !tick_apre; g++) cycle();
    chk("R11 first apre delay", ncyc - rel, 3);

    // R1 R2: free-running periods from the vector table
    foreach (VEC[v]) begin
      do_reset(VEC[v][0], VEC[v][1], 1'b0);
      for (int g = 0; g < 300 && !tick_apre; g++) cycle();
      t1 = ncyc;
      cycle();
      for (int g = 0; g < 300 && !tick_apre; g++) cycle();
      chk("R1 apre period", ncyc - t1, VEC[v][2]);
      for (int g = 0; g < 70000 && nspre < 2; g++) cycle();
      chk("R2 spre period", spre_log[1] - spre_log[0], VEC[v][3]);
    end

    // R4 R5 R6 R8: acquire in wide window, then stay aligned
    do_reset(3, 15, 1'b1);
    sync_t0(t0);
    rises[0] = t0 + 54; rises[1] = t0 + 118; rises[2] = t0 + 182; rises[3] = t0 + 246;
    nrise = 4;
    repeat (300) cycle();
    chk("R4 R6 forced tick", spre_log[0] - t0, 56);
    chk("R8 aligned tick 1", spre_log[1] - t0, 120);
    chk("R8 aligned tick 3", spre_log[3] - t0, 248);
    chk("R6 unlocked before", int'(lock_hist[(t0 + 50) % 512]), 0);
    chk("R6 locked after", int'(lock_hist[(t0 + 57) % 512]), 1);
    chk("R8 still locked", int'(lock_hist[(t0 + 250) % 512]), 1);
    det_en = 1'b0;
    cycle();
    chk("R3 lock drops on disable", int'(ref_locked), 0);

    // R7: slower reference, restart after the natural tick
    do_reset(3, 15, 1'b1);
    sync_t0(t0);
    rises[0] = t0 + 54; rises[1] = t0 + 120; rises[2] = t0 + 186; rises[3] = t0 + 252;
    nrise = 4;
    repeat (300) cycle();
    chk("R7 natural tick", spre_log[1] - t0, 120);
    chk("R7 stretched period a", spre_log[2] - spre_log[1], 66);
    chk("R7 stretched period b", spre_log[3] - spre_log[2], 66);
    chk("R7 locked", int'(lock_hist[(t0 + 260) % 512]), 1);

    // R6: faster reference, early tick
    do_reset(3, 15, 1'b1);
    sync_t0(t0);
    rises[0] = t0 + 54; rises[1] = t0 + 116; rises[2] = t0 + 178;
    nrise = 3;
    repeat (250) cycle();
    chk("R6 shortened period a", spre_log[1] - spre_log[0], 62);
    chk("R6 shortened period b", spre_log[2] - spre_log[1], 62);

    // R10: reference stops
    do_reset(3, 15, 1'b1);
    sync_t0(t0);
    rises[0] = t0 + 54; rises[1] = t0 + 118;
    nrise = 2;
    repeat (300) cycle();
    chk("R10 locked while present", int'(lock_hist[(t0 + 150) % 512]), 1);
    chk("R10 lock lost", int'(lock_hist[(t0 + 200) % 512]), 0);
    chk("R10 free tick", spre_log[3] - t0, 248);

    // R5 R10: narrow window rejects, wide window captures
    do_reset(3, 15, 1'b1);
    sync_t0(t0);
    rises[0] = t0 + 54; rises[1] = t0 + 118; rises[2] = t0 + 172; rises[3] = t0 + 236;
    nrise = 4;
    repeat (300) cycle();
    chk("R5 narrow ignores early edge", spre_log[2] - t0, 184);
    chk("R10 lost after miss", int'(lock_hist[(t0 + 200) % 512]), 0);
    chk("R5 wide window captures", spre_log[3] - t0, 238);
    chk("R5 relocked", int'(lock_hist[(t0 + 245) % 512]), 1);

    // R9: second edge inside the same window ignored
    do_reset(3, 15, 1'b1);
    sync_t0(t0);
    rises[0] = t0 + 54; rises[1] = t0 + 118; rises[2] = t0 + 122;
    nrise = 3;
    repeat (250) cycle();
    chk("R9 one restart per window", spre_log[2] - t0, 184);

    // R3: detection disabled, reference ignored
    do_reset(3, 15, 1'b0);
    sync_t0(t0);
    rises[0] = t0 + 54; rises[1] = t0 + 118;
    nrise = 2;
    repeat (200) cycle();
    chk("R3 tick unaffected a", spre_log[0] - t0, 64);
    chk("R3 tick unaffected b", spre_log[1] - t0, 128);
    chk("R3 lock held low", int'(lock_hist[(t0 + 130) % 512]), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule